// File: doc/BRIEF.md
# In-Order Completion Queue

This block tracks instructions between issue and retirement in a core that issues in program order but whose execution units finish out of order. Each time the issue logic sends an instruction, it claims the next ring slot. The slot index is handed back as the instruction's tag. An execution unit that finishes an instruction presents that tag on one of the completion ports, and the matching slot is marked finished.

The queue retires finished slots strictly in program order, starting from the oldest one. It retires at most five slots per clock. The retire scan looks only at finished flags that were registered in earlier cycles, so a completion can never retire in the cycle in which it arrives.

Free and used counts are exported so the issue stage can stall. A full flag blocks allocation whenever no slot is free. A completion that names an empty slot is dropped and reported on an error output.

Top module: `cmpl_queue`

## Requirements
- R1: After a synchronous active-low reset, free_cnt is 16, used_cnt is 0, full is 0, alloc_tag is 0, ret_cnt is 0 and cmp_err is 0.
- R2: An accepted allocation (alloc_req high and full low) takes the slot shown on alloc_tag and increments used_cnt by one. After that edge, alloc_tag shows the next index modulo 16.
- R3: full is 1 exactly when free_cnt is 0. While full is 1, alloc_req is ignored: used_cnt and alloc_tag keep their values.
- R4: Completions may arrive in any order. A finished slot that is not at the head does not retire until every older slot has finished.
- R5: Each cycle, ret_cnt shows how many slots retire at the coming edge. It counts consecutive finished slots from the head and is capped at 5. Lane i of ret_tags (bits 4*i+3 down to 4*i) carries the tag head+i modulo 16. The unused lanes read 0.
- R6: A completion presented in cycle N affects ret_cnt no earlier than cycle N+1.
- R7: free_cnt + used_cnt equals 16 in every cycle.
- R8: A completion whose tag names a slot that is not allocated raises cmp_err in that same cycle and has no effect. In particular, a later allocation of that slot starts out unfinished.
- R9: All seven completion ports act in the same cycle. Port p uses valid bit p and tag bits 4*p+3 down to 4*p.
- R10: At each edge, used_cnt changes by the number of accepted allocations minus ret_cnt, and the head advances by ret_cnt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Issue logic claims a slot this cycle |
| alloc_tag | output | 4 | Slot index given to the claiming instruction |
| full | output | 1 | No free slot; allocation is refused |
| free_cnt | output | 5 | Number of empty slots |
| used_cnt | output | 5 | Number of allocated slots |
| cmp_valid | input | 7 | One finish strobe per execution unit |
| cmp_tag | input | 28 | Packed 4-bit tags, one per completion port |
| cmp_err | output | 1 | A strobed completion named an unallocated slot |
| ret_cnt | output | 3 | Slots retiring at the coming edge (0 to 5) |
| ret_tags | output | 20 | Packed tags of the retiring slots, oldest in lane 0 |

## Verification
The hardest situation to reach is a full ring whose head slot is the only one unfinished, with the pointers wrapped part-way round. In that state a single completion releases a run of retirements that each stop at the five-slot cap and cross index 15 back to 0. The stimulus first retires a few slots so that the head sits at 4. It then fills all sixteen slots and finishes every slot except the head, seven per cycle, while checking that nothing retires. Finally it finishes the head and follows the 5, 5, 5, 1 drain, lane by lane.

// File: rtl/cq_pkg.sv
// Package: shared sizing defaults for the completion queue.
// Assumes the ring depth is a power of two so that pointers wrap by truncation.
package cq_pkg;
    localparam int CQ_DEPTH     = 16;
    localparam int CQ_CMP_PORTS = 7;
    localparam int CQ_RET_LANES = 5;
endpackage

// File: rtl/cq_ptr_ctrl.sv
// Module: cq_ptr_ctrl
// Keeps the head and tail ring pointers and the free and used counters.
// Assumes: alloc_fire is never high while full, and ret_cnt never exceeds used_cnt.
module cq_ptr_ctrl #(
    parameter int DEPTH = 16,
    parameter int RET_W = 5,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int RCW  = $clog2(RET_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_fire,
    input  logic [RCW-1:0] ret_cnt,
    output logic [TW-1:0]  head,
    output logic [TW-1:0]  tail,
    output logic [CW-1:0]  free_cnt,
    output logic [CW-1:0]  used_cnt,
    output logic           full
);
    logic [TW-1:0] head_q, tail_q;
    logic [CW-1:0] free_q, used_q;

    // Advance the pointers and the counters by this cycle's allocation and retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            free_q <= CW'(DEPTH);
            used_q <= '0;
        end else begin
            head_q <= head_q + TW'(ret_cnt);
            if (alloc_fire)
                tail_q <= tail_q + 1'b1;
            used_q <= used_q + CW'(alloc_fire) - CW'(ret_cnt);
            free_q <= free_q - CW'(alloc_fire) + CW'(ret_cnt);
        end
    end

    // Drive the pointer and counter outputs.
    always_comb begin
        head     = head_q;
        tail     = tail_q;
        free_cnt = free_q;
        used_cnt = used_q;
        full     = (free_q == '0);
    end

    AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, free_q} + {1'b0, used_q}) == (CW + 1)'(DEPTH)); // R7
    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> tail_q == $past(tail_q) + 1'b1); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= CW'(DEPTH)); // R3
endmodule

// File: rtl/cq_entry_array.sv
// Module: cq_entry_array
// Holds a valid flag and a finished flag for every ring slot, and applies the
// allocations, retirements and completions.
// Assumes: one allocation at most per cycle, and that ret_mask covers only valid slots.
module cq_entry_array #(
    parameter int DEPTH = 16,
    parameter int NCMP  = 7,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_fire,
    input  logic [TW-1:0]     tail,
    input  logic [DEPTH-1:0]  ret_mask,
    input  logic [NCMP-1:0]   cmp_valid,
    input  logic [NCMP*TW-1:0] cmp_tag,
    output logic [DEPTH-1:0]  valid,
    output logic [DEPTH-1:0]  done,
    output logic              cmp_err
);
    logic [DEPTH-1:0] valid_q, done_q, hit;

    // Decode every completion port into a per-slot hit vector.
    always_comb begin
        hit = '0;
        for (int p = 0; p < NCMP; p++)
            if (cmp_valid[p])
                hit[cmp_tag[p*TW +: TW]] = 1'b1;
    end

    // Flag any completion whose slot is not currently allocated.
    always_comb begin
        cmp_err = 1'b0;
        for (int p = 0; p < NCMP; p++)
            if (cmp_valid[p] && !valid_q[cmp_tag[p*TW +: TW]])
                cmp_err = 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Per-slot flags: allocation first, then retirement, then completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                done_q[i]  <= 1'b0;
            end else if (alloc_fire && tail == TW'(i)) begin
                valid_q[i] <= 1'b1;
                done_q[i]  <= 1'b0;
            end else if (ret_mask[i]) begin
                valid_q[i] <= 1'b0;
                done_q[i]  <= 1'b0;
            end else if (hit[i] && valid_q[i]) begin
                done_q[i]  <= 1'b1;
            end
        end
    end

    // Present the flags to the retire scan.
    always_comb begin
        valid = valid_q;
        done  = done_q;
    end

    AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q & ~valid_q) == '0); // R8
    AST_RETIRE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_mask & ~(valid_q & done_q)) == '0); // R4
endmodule

// File: rtl/cq_retire_scan.sv
// Module: cq_retire_scan
// Walks up to RET_W slots from the head and stops at the first slot that is not
// both valid and finished. Purely combinational; it uses registered flags only.
// Assumes DEPTH is a power of two, so that index wrap is plain truncation.
module cq_retire_scan #(
    parameter int DEPTH = 16,
    parameter int RET_W = 5,
    localparam int TW   = $clog2(DEPTH),
    localparam int RCW  = $clog2(RET_W + 1)
) (
    input  logic [TW-1:0]       head,
    input  logic [DEPTH-1:0]    valid,
    input  logic [DEPTH-1:0]    done,
    output logic [RCW-1:0]      ret_cnt,
    output logic [RET_W*TW-1:0] ret_tags,
    output logic [DEPTH-1:0]    ret_mask
);
    logic          go;
    logic [TW-1:0] idx;

    // Find the finished run at the head, record its tags and mark its slots.
    always_comb begin
        ret_cnt  = '0;
        ret_tags = '0;
        ret_mask = '0;
        go       = 1'b1;
        idx      = head;
        for (int i = 0; i < RET_W; i++) begin
            idx = head + TW'(i);
            if (go && valid[idx] && done[idx]) begin
                ret_cnt              = ret_cnt + 1'b1;
                ret_tags[i*TW +: TW] = idx;
                ret_mask[idx]        = 1'b1;
            end else begin
                go = 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmpl_queue.sv
// Module: cmpl_queue (top)
// In-order completion ring: allocate at the tail, finish by tag on any port,
// retire up to RET_W finished slots from the head each cycle.
// Assumes: the caller honours full, and DEPTH is a power of two.
module cmpl_queue #(
    parameter int DEPTH = cq_pkg::CQ_DEPTH,
    parameter int NCMP  = cq_pkg::CQ_CMP_PORTS,
    parameter int RET_W = cq_pkg::CQ_RET_LANES,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int RCW  = $clog2(RET_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_req,
    output logic [TW-1:0]      alloc_tag,
    output logic               full,
    output logic [CW-1:0]      free_cnt,
    output logic [CW-1:0]      used_cnt,
    input  logic [NCMP-1:0]    cmp_valid,
    input  logic [NCMP*TW-1:0] cmp_tag,
    output logic               cmp_err,
    output logic [RCW-1:0]     ret_cnt,
    output logic [RET_W*TW-1:0] ret_tags
);
    logic             alloc_fire;
    logic [TW-1:0]    head, tail;
    logic [DEPTH-1:0] valid, done, ret_mask;

    // Accept an allocation only outside reset and while a slot is free.
    always_comb begin
        alloc_fire = rst_n && alloc_req && !full;
        alloc_tag  = tail;
    end

    cq_ptr_ctrl #(.DEPTH(DEPTH), .RET_W(RET_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .ret_cnt(ret_cnt),
        .head(head), .tail(tail), .free_cnt(free_cnt), .used_cnt(used_cnt),
        .full(full)
    );

    cq_entry_array #(.DEPTH(DEPTH), .NCMP(NCMP)) u_ent (
        .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .tail(tail),
        .ret_mask(ret_mask), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
        .valid(valid), .done(done), .cmp_err(cmp_err)
    );

    cq_retire_scan #(.DEPTH(DEPTH), .RET_W(RET_W)) u_scan (
        .head(head), .valid(valid), .done(done),
        .ret_cnt(ret_cnt), .ret_tags(ret_tags), .ret_mask(ret_mask)
    );

    AST_RET_WITHIN_USED: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(ret_cnt) <= used_cnt); // R5
    AST_RET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cnt <= RCW'(RET_W)); // R5
    AST_FULL_HOLDS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> alloc_tag == $past(alloc_tag)); // R3
    AST_USED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> used_cnt == $past(used_cnt) + CW'($past(alloc_fire)) - CW'($past(ret_cnt))); // R10
endmodule

// File: tb/sim_cmpl_queue.sv
module sim_cmpl_queue;
    localparam int TW = 4;
    localparam int NP = 7;
    // Vector fields: alloc, cmp_valid, cmp_tag, exp tag, exp used, exp ret, exp lane0, exp err
    localparam int VW = 1 + NP + NP*TW + 4 + 5 + 3 + 4 + 1;
    localparam int NV = 9;
    localparam logic [VW-1:0] TBL [NV] = '{
        {1'b1, 7'b0000000, 28'h0000000, 4'd0, 5'd0, 3'd0, 4'd0, 1'b0},
        {1'b1, 7'b0000000, 28'h0000000, 4'd1, 5'd1, 3'd0, 4'd0, 1'b0},
        {1'b1, 7'b0000001, 28'h0000001, 4'd2, 5'd2, 3'd0, 4'd0, 1'b0},
        {1'b1, 7'b0000000, 28'h0000000, 4'd3, 5'd3, 3'd0, 4'd0, 1'b0},
        {1'b0, 7'b0101000, 28'h0200000, 4'd4, 5'd4, 3'd0, 4'd0, 1'b0},
        {1'b0, 7'b0000000, 28'h0000000, 4'd4, 5'd4, 3'd3, 4'd0, 1'b0},
        {1'b0, 7'b1000000, 28'h7000000, 4'd4, 5'd1, 3'd0, 4'd0, 1'b1},
        {1'b1, 7'b0000010, 28'h0000030, 4'd4, 5'd1, 3'd0, 4'd0, 1'b0},
        {1'b0, 7'b0000000, 28'h0000000, 4'd5, 5'd2, 3'd1, 4'd3, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, alloc_req = 1'b0;
    logic [NP-1:0] cmp_valid = '0;
    logic [NP*TW-1:0] cmp_tag = '0;
    logic [3:0] alloc_tag;
    logic full, cmp_err;
    logic [4:0] free_cnt, used_cnt;
    logic [2:0] ret_cnt;
    logic [19:0] ret_tags;
    int n_chk = 0, n_bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    cmpl_queue u0 (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_tag(alloc_tag),
        .full(full), .free_cnt(free_cnt), .used_cnt(used_cnt),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_err(cmp_err),
        .ret_cnt(ret_cnt), .ret_tags(ret_tags)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edge_go;
        @(posedge clk);
        #1;
    endtask

    task automatic settle;
        #1.5;
        chk("R7 free+used", int'(free_cnt) + int'(used_cnt), 16);
    endtask

    task automatic clear_cmp;
        cmp_valid = '0;
        cmp_tag   = '0;
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) edge_go();
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 free", free_cnt, 16);
        chk("R1 used", used_cnt, 0);
        chk("R1 full", full, 0);
        chk("R1 tag", alloc_tag, 0);
        chk("R1 ret", ret_cnt, 0);
        chk("R1 err", cmp_err, 0);

        // Table walk: allocation, out-of-order completion, retirement, error
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            e = TBL[v];
            edge_go();
            alloc_req = e[VW-1];
            cmp_valid = e[VW-2 -: NP];
            cmp_tag   = e[VW-2-NP -: NP*TW];
            settle();
            chk("R2 tag", alloc_tag, e[16:13]);
            chk("R10 used", used_cnt, e[12:8]);
            chk("R4/R5 ret", ret_cnt, e[7:5]);
            if (e[7:5] != 0) chk("R5 lane0", ret_tags[3:0], e[4:1]);
            chk("R8 err", cmp_err, e[0]);
        end
        // State now: head 4, tail 5, slot 4 allocated and unfinished.

        // Fill the ring: 15 more allocations, tags 5..15 then 0..3
        for (int k = 0; k < 15; k++) begin
            edge_go();
            alloc_req = 1'b1;
            clear_cmp();
            settle();
            chk("R2 wrap tag", alloc_tag, (5 + k) % 16);
        end
        edge_go();
        alloc_req = 1'b1;
        settle();
        chk("R3 full", full, 1);
        chk("R3 free", free_cnt, 0);
        edge_go();
        settle();
        chk("R3 ignored used", used_cnt, 16);
        chk("R3 ignored tag", alloc_tag, 4);
        alloc_req = 1'b0;

        // Finish every slot except the head, seven per cycle (R9)
        for (int g = 0; g < 3; g++) begin
            edge_go();
            clear_cmp();
            for (int p = 0; p < NP; p++) begin
                int t;
                t = 5 + g*NP + p;
                if (t < 20) begin
                    cmp_valid[p] = 1'b1;
                    cmp_tag[p*TW +: TW] = 4'(t % 16);
                end
            end
            settle();
            chk("R4 head blocks", ret_cnt, 0);
        end
        edge_go();
        clear_cmp();
        cmp_valid[2] = 1'b1;
        cmp_tag[2*TW +: TW] = 4'd4;
        settle();
        chk("R6 same cycle", ret_cnt, 0);
        edge_go();
        clear_cmp();
        settle();
        chk("R5 cap", ret_cnt, 5);
        chk("R5 lane0", ret_tags[3:0], 4);
        chk("R5 lane4", ret_tags[19:16], 8);
        edge_go();
        settle();
        chk("R10 used after", used_cnt, 11);
        chk("R9 all ports", ret_cnt, 5);
        chk("R5 lane0 b", ret_tags[3:0], 9);
        edge_go();
        settle();
        chk("R5 wrap cnt", ret_cnt, 5);
        chk("R5 wrap lane1", ret_tags[7:4], 15);
        chk("R5 wrap lane2", ret_tags[11:8], 0);
        edge_go();
        settle();
        chk("R5 tail cnt", ret_cnt, 1);
        chk("R5 tail lane0", ret_tags[3:0], 3);
        chk("R5 unused lane", ret_tags[7:4], 0);
        edge_go();
        settle();
        chk("R5 empty", ret_cnt, 0);
        chk("R10 drained", used_cnt, 0);

        // Completion on an empty slot is flagged and has no effect (R8)
        edge_go();
        cmp_valid[0] = 1'b1;
        cmp_tag[3:0] = 4'd4;
        settle();
        chk("R8 err raised", cmp_err, 1);
        edge_go();
        clear_cmp();
        alloc_req = 1'b1;
        settle();
        chk("R8 tag reused", alloc_tag, 4);
        edge_go();
        alloc_req = 1'b0;
        settle();
        chk("R8 no stale finish", ret_cnt, 0);
        chk("R8 err clear", cmp_err, 0);
        edge_go();
        cmp_valid[6] = 1'b1;
        cmp_tag[27:24] = 4'd4;
        settle();
        chk("R8 valid cmp no err", cmp_err, 0);
        edge_go();
        clear_cmp();
        settle();
        chk("R4 single retire", ret_cnt, 1);
        finish_run();
    end
endmodule